// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a byte-addressed serial memory that answers on a two-wire bus. A fast system clock samples the bus clock and data lines, and the block finds Start and Stop conditions. It takes in a device address byte and two word address bytes. It answers each byte by enabling an open-drain pull-down on the data line during the ninth clock. Toward the storage array it offers a plain byte port: a one-cycle write strobe with address and data, a one-cycle read request whose data comes back on the next cycle, and a busy input that the array raises while an internal write cycle runs.

The word address is 17 bits wide. Its top bit travels in the device address byte. A counter keeps the current address from one transaction to the next, so a read that sends no address continues where the last access stopped. While the array reports busy, the block leaves its own address unanswered, and a master can poll until the write cycle ends.

Top module: `tws_mem_slave`

## Requirements
- R1: During and right after reset the pull-down enable, the write strobe and the read request are all low.
- R2: The block acknowledges a device address byte when bits 7..4 are 1010 and bits 3..2 equal `hw_addr_i`, and not otherwise. An unanswered byte leaves the block ignoring the bus until the next Start. Bit 0 selects the direction (1 read, 0 write).
- R3: While `mem_busy_i` is high, a matching device address byte is not acknowledged.
- R4: In write mode, bit 1 of the device byte becomes address bit 16. The next two bytes give bits 15..8 and then 7..0, and each is acknowledged. Every further byte gives one single-cycle `mem_we_o` pulse, with the address and data, and an acknowledge.
- R5: Within one write transaction, successive data bytes raise only the low 8 address bits and wrap within the 256-byte page. Bits 16..8 stay unchanged.
- R6: A random read is a write-mode address phase, a repeated Start and a read-mode device byte. It returns the byte at the given address, MSB first, with each data bit changing only after an SCL falling edge.
- R7: While the master acknowledges, a read goes on at the next address. The read address wraps from 0x1FFFF to 0.
- R8: A read-mode device byte with no address phase returns the byte at the address after the last one read or written. In a read-mode device byte, bit 1 is ignored.
- R9: A master no-acknowledge ends a read: the block releases SDA and issues no further read requests.
- R10: A Start or Stop in the middle of a byte aborts the transfer. The partial byte is discarded, no write strobe is issued, and a following transaction works normally.
- R11: The block only ever enables a pull-down, and it turns the pull-down on only in the cycle that follows a detected SCL falling edge.
- R12: A Stop releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired level) |
| hw_addr_i | input | 2 | Strapped address select compared with device byte bits 3..2 |
| sda_oe_o | output | 1 | Pull-down enable for the data line (1 = drive low) |
| mem_we_o | output | 1 | One-cycle write strobe to the array |
| mem_re_o | output | 1 | One-cycle read request to the array |
| mem_addr_o | output | 17 | Byte address for the strobe or request |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after `mem_re_o` |
| mem_busy_i | input | 1 | Array internal write cycle in progress |

## Verification
The hardest states to reach from the pins are the two address wraps. The page wrap needs a write that starts two bytes before a page end. The array wrap needs a random read aimed at the very last byte, with the master acknowledging once so that the counter rolls to zero. The bench sets both up with explicit address phases and then checks the write strobe log and the returned bytes against an address arithmetic of its own. Aborts are reached by breaking a data byte after four or five bits with a repeated Start or a Stop. A full sweep of strap values, address select bits and type nibbles covers the address match.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_PRE,
    ST_TX,
    ST_RXACK
  } tws_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DATA
  } tws_kind_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_p;
  logic              sda_p;
  logic              scl_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else begin
          scl_q[g] <= scl_i;
          sda_q[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else begin
          scl_q[g] <= scl_q[g-1];
          sda_q[g] <= sda_q[g-1];
        end
      end
    end
  end

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tws_addr_ctr.sv
module tws_addr_ctr #(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_d;
  logic [PAGE_W-1:0] low_inc;

  assign low_inc = addr[PAGE_W-1:0] + PAGE_W'(1);

  always_comb begin
    addr_d = addr;
    if (load)          addr_d = load_val;
    else if (inc_full) addr_d = addr + ADDR_W'(1);
    else if (inc_page) addr_d = {addr[ADDR_W-1:PAGE_W], low_inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_d;
  end
endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int PAGE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        hw_addr_i,
  output logic              sda_oe_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              mem_busy_i
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic sda_s, scl_rise_w, scl_fall_w, start_w, stop_w;

  tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w)
  );

  tws_state_e        state, state_d;
  tws_kind_e         kind, kind_d;
  logic [CNT_W-1:0]  cnt, cnt_d;
  logic [BYTE_W-1:0] rx_sh, rx_sh_d;
  logic [BYTE_W-1:0] tx_sh, tx_sh_d;
  logic [BYTE_W-1:0] ahi, ahi_d;
  logic              a16, a16_d;
  logic              oe_d, we_d, re_d, re_q;
  logic [ADDR_W-1:0] maddr_d;
  logic [BYTE_W-1:0] mwdata_d;
  logic              c_load, c_pinc, c_finc;
  logic [ADDR_W-1:0] ctr;
  logic [ADDR_W-1:0] load_val;
  logic              dev_hit;

  assign load_val = ADDR_W'({a16, ahi, rx_sh});
  assign dev_hit  = (rx_sh[7:4] == DEV_TYPE) && (rx_sh[3:2] == hw_addr_i) && !mem_busy_i;

  tws_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (c_load),
    .load_val (load_val),
    .inc_page (c_pinc),
    .inc_full (c_finc),
    .addr     (ctr)
  );

  always_comb begin
    state_d  = state;
    kind_d   = kind;
    cnt_d    = cnt;
    rx_sh_d  = rx_sh;
    tx_sh_d  = tx_sh;
    ahi_d    = ahi;
    a16_d    = a16;
    oe_d     = sda_oe_o;
    we_d     = 1'b0;
    re_d     = 1'b0;
    maddr_d  = mem_addr_o;
    mwdata_d = mem_wdata_o;
    c_load   = 1'b0;
    c_pinc   = 1'b0;
    c_finc   = 1'b0;
    if (re_q) tx_sh_d = mem_rdata_i;
    if (start_w) begin
      state_d = ST_RX;
      kind_d  = K_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_w) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise_w && cnt != CNT_FULL) begin
            rx_sh_d = {rx_sh[BYTE_W-2:0], sda_s};
            cnt_d   = cnt + CNT_ONE;
          end else if (scl_fall_w && cnt == CNT_FULL) begin
            case (kind)
              K_DEV: begin
                if (dev_hit) begin
                  oe_d = 1'b1;
                  if (rx_sh[0]) begin
                    state_d = ST_PRE;
                    re_d    = 1'b1;
                    maddr_d = ctr;
                    c_finc  = 1'b1;
                  end else begin
                    state_d = ST_ACK;
                    kind_d  = K_AHI;
                    a16_d   = rx_sh[1];
                  end
                end else begin
                  state_d = ST_IDLE;
                end
              end
              K_AHI: begin
                oe_d    = 1'b1;
                state_d = ST_ACK;
                ahi_d   = rx_sh;
                kind_d  = K_ALO;
              end
              K_ALO: begin
                oe_d    = 1'b1;
                state_d = ST_ACK;
                c_load  = 1'b1;
                kind_d  = K_DATA;
              end
              default: begin
                oe_d     = 1'b1;
                state_d  = ST_ACK;
                we_d     = 1'b1;
                maddr_d  = ctr;
                mwdata_d = rx_sh;
                c_pinc   = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall_w) begin
            oe_d    = 1'b0;
            state_d = ST_RX;
            cnt_d   = '0;
          end
        end
        ST_PRE: begin
          if (scl_fall_w) begin
            oe_d    = ~tx_sh[BYTE_W-1];
            tx_sh_d = {tx_sh[BYTE_W-2:0], 1'b1};
            cnt_d   = CNT_ONE;
            state_d = ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall_w) begin
            if (cnt == CNT_FULL) begin
              oe_d    = 1'b0;
              state_d = ST_RXACK;
            end else begin
              oe_d    = ~tx_sh[BYTE_W-1];
              tx_sh_d = {tx_sh[BYTE_W-2:0], 1'b1};
              cnt_d   = cnt + CNT_ONE;
            end
          end
        end
        ST_RXACK: begin
          if (scl_rise_w) begin
            if (!sda_s) begin
              state_d = ST_PRE;
              re_d    = 1'b1;
              maddr_d = ctr;
              c_finc  = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      kind        <= K_DEV;
      cnt         <= '0;
      rx_sh       <= '0;
      tx_sh       <= '1;
      ahi         <= '0;
      a16         <= 1'b0;
      sda_oe_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_re_o    <= 1'b0;
      re_q        <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      state       <= state_d;
      kind        <= kind_d;
      cnt         <= cnt_d;
      rx_sh       <= rx_sh_d;
      tx_sh       <= tx_sh_d;
      ahi         <= ahi_d;
      a16         <= a16_d;
      sda_oe_o    <= oe_d;
      mem_we_o    <= we_d;
      mem_re_o    <= re_d;
      re_q        <= mem_re_o;
      mem_addr_o  <= maddr_d;
      mem_wdata_o <= mwdata_d;
    end
  end
endmodule

// File: rtl/tws_mem_slave_chk.sv
module tws_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe_o,
  input logic mem_we_o,
  input logic mem_re_o,
  input logic scl_fall,
  input logic stop_det
);
  // R11: pull-down switches on only right after an SCL falling edge
  p_oe_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall));

  // R12: a Stop releases the data line
  p_stop_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);

  // R4: each received data byte yields a single-cycle strobe
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

  // R7: each read step issues a single-cycle request
  p_re_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> !mem_re_o);

  // R6: reads and writes never overlap on the array port
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));
endmodule

bind tws_mem_slave tws_mem_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe_o (sda_oe_o),
  .mem_we_o (mem_we_o),
  .mem_re_o (mem_re_o),
  .scl_fall (scl_fall_w),
  .stop_det (stop_w)
);

// File: tb/tws_mem_slave_test.sv
module tws_mem_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m, sda_m;
  logic [1:0]  hw;
  logic        busy;
  logic [7:0]  rdata;
  logic        sda_oe, we, re;
  logic [16:0] maddr;
  logic [7:0]  wdata;
  logic        sda_line;

  assign sda_line = sda_m & ~sda_oe;

  tws_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .hw_addr_i(hw),
    .sda_oe_o(sda_oe), .mem_we_o(we), .mem_re_o(re), .mem_addr_o(maddr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_busy_i(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] store [int];
  int wlog_a [0:31];
  int wlog_d [0:31];
  int wcnt = 0;
  int rcnt = 0;

  function automatic logic [7:0] init_b(input int a);
    return 8'((a * 37) ^ (a >>> 9));
  endfunction

  always @(posedge clk) begin
    if (we) begin
      store[int'(maddr)] = wdata;
      if (wcnt < 32) begin
        wlog_a[wcnt] = int'(maddr);
        wlog_d[wcnt] = int'(wdata);
      end
      wcnt = wcnt + 1;
    end
    if (re) begin
      rcnt = rcnt + 1;
      rdata <= store.exists(int'(maddr)) ? store[int'(maddr)] : init_b(int'(maddr));
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw;
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; qw; scl_m = 1'b1; qw; sda_m = 1'b0; qw; scl_m = 1'b0; qw;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qw; scl_m = 1'b1; qw; sda_m = 1'b1; qw;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qw; scl_m = 1'b1; qw; scl_m = 1'b0; qw;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; qw; scl_m = 1'b1; qw;
    ack = ~sda_line;
    scl_m = 1'b0; qw;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw; scl_m = 1'b1; qw; b[i] = sda_line; scl_m = 1'b0;
    end
    qw; sda_m = mack ? 1'b0 : 1'b1; qw; scl_m = 1'b1; qw; scl_m = 1'b0; qw; sda_m = 1'b1;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int w0, r0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; hw = 2'b01; busy = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", int'(sda_oe), 0);
    chk("R1 we in reset", int'(we), 0);
    chk("R1 re in reset", int'(re), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", int'(sda_oe), 0);

    // R2: strap vs select-bit sweep
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        hw = 2'(p);
        bus_start();
        send_byte({4'b1010, 2'(s), 2'b00}, ack);
        chk($sformatf("R2 strap %0d sel %0d", p, s), int'(ack), int'(p == s));
        bus_stop();
      end
    end
    hw = 2'b01;
    // R2: type nibble sweep
    for (int id = 0; id < 16; id++) begin
      bus_start();
      send_byte({4'(id), 2'b01, 2'b00}, ack);
      chk($sformatf("R2 type %0h", id), int'(ack), int'(id == 10));
      bus_stop();
    end

    // R4/R5: page write across page end
    w0 = wcnt;
    bus_start();
    send_byte(8'hA6, ack); chk("R4 dev ack", int'(ack), 1);
    send_byte(8'h23, ack); chk("R4 hi ack", int'(ack), 1);
    send_byte(8'hFE, ack); chk("R4 lo ack", int'(ack), 1);
    send_byte(8'h11, ack); chk("R4 data ack", int'(ack), 1);
    send_byte(8'h22, ack);
    send_byte(8'h33, ack);
    bus_stop();
    qw;
    chk("R12 released after stop", int'(sda_oe), 0);
    chk("R4 strobe count", wcnt - w0, 3);
    chk("R4 first addr", wlog_a[w0], 32'h123FE);
    chk("R4 first data", wlog_d[w0], 32'h11);
    chk("R5 second addr", wlog_a[w0+1], 32'h123FF);
    chk("R5 page wrap addr", wlog_a[w0+2], 32'h12300);
    chk("R5 page wrap data", wlog_d[w0+2], 32'h33);

    // R6/R7: random then sequential read
    bus_start();
    send_byte(8'hA6, ack); send_byte(8'h23, ack); send_byte(8'hFE, ack);
    bus_start();
    send_byte(8'hA7, ack); chk("R6 read dev ack", int'(ack), 1);
    recv_byte(1'b1, b); chk("R6 random read", int'(b), 32'h11);
    recv_byte(1'b0, b); chk("R7 sequential read", int'(b), 32'h22);
    r0 = rcnt;
    chk("R9 released after nack", int'(sda_line), 1);
    bus_stop();
    repeat (4) qw;
    chk("R9 no request after nack", rcnt - r0, 0);

    // R8: current address read
    bus_start();
    send_byte(8'hA7, ack);
    recv_byte(1'b0, b); chk("R8 current address", int'(b), int'(init_b(32'h12400)));
    bus_stop();

    // R7: array wrap
    bus_start();
    send_byte(8'hA6, ack); send_byte(8'hFF, ack); send_byte(8'hFF, ack);
    bus_start();
    send_byte(8'hA7, ack);
    recv_byte(1'b1, b); chk("R7 last byte", int'(b), int'(init_b(32'h1FFFF)));
    recv_byte(1'b0, b); chk("R7 wrap to zero", int'(b), int'(init_b(0)));
    bus_stop();

    // R3: busy
    busy = 1'b1;
    bus_start();
    send_byte(8'hA6, ack); chk("R3 nack while busy", int'(ack), 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(8'hA5, ack); chk("R3 ack after busy", int'(ack), 1);
    recv_byte(1'b0, b); chk("R8 current after wrap", int'(b), int'(init_b(1)));
    bus_stop();

    // R10: repeated Start mid-byte
    w0 = wcnt;
    bus_start();
    send_byte(8'hA4, ack); send_byte(8'h00, ack); send_byte(8'h40, ack);
    send_bits(8'h5A, 4);
    bus_start();
    send_byte(8'hA4, ack); send_byte(8'h00, ack); send_byte(8'h41, ack);
    send_byte(8'h77, ack); chk("R10 ack after abort", int'(ack), 1);
    bus_stop();
    chk("R10 one strobe after start abort", wcnt - w0, 1);
    chk("R10 addr after abort", wlog_a[w0], 32'h00041);
    chk("R10 data after abort", wlog_d[w0], 32'h77);

    // R10: Stop mid-byte
    w0 = wcnt;
    bus_start();
    send_byte(8'hA4, ack); send_byte(8'h00, ack); send_byte(8'h50, ack);
    send_bits(8'hC3, 5);
    bus_stop();
    qw;
    chk("R10 no strobe after stop abort", wcnt - w0, 0);
    chk("R12 released after abort", int'(sda_oe), 0);

    finish_run();
  end
endmodule